// File: doc/BRIEF.md
# Serial Identification Code Responder

This controller answers a host's request for identification by sending a fixed code out of a single wire, one bit per clock cycle. While nobody asks, it rests in a waiting state with the output low. When the request input is seen high on a rising clock edge, the controller walks through one state per code bit. It presents the least significant bit of the code first and the most significant bit last, and then it goes back to waiting.

The code value and its width are parameters. The default is the 4-bit pattern 1011, which appears on the wire as 1, 1, 0, 1. The request is a plain level input with no acknowledgement. Only the request line and the serial bit form the interface, so the data path carries no valid/ready signalling. A host that reads the wire must sample it on the four cycles that follow the edge at which it raised the request.

Top module: `serial_key_responder`

## Requirements
- R1: A synchronous active-high reset puts the controller in the waiting state, and `bit_o` is 0 in the cycle after any edge that sees reset, even when `req_i` is high at that edge.
- R2: In the waiting state `bit_o` is 0.
- R3: Suppose the controller is waiting and a rising edge sees `req_i` high. Sending then begins, and in the next cycle `bit_o` carries code bit 0, the least significant bit.
- R4: Over the CODE_W cycles after the starting edge, `bit_o` carries code bits 0, 1, ..., CODE_W-1 in that order, one per cycle. For the default code 1011 this gives 1, 1, 0, 1.
- R5: At the edge after the last code bit the controller returns to waiting whatever the value of `req_i`, so the wire is 0 for at least one cycle after each code.
- R6: While a code is being sent, `req_i` has no effect: the bit sequence on `bit_o` is unchanged and no new code starts before the return to waiting.
- R7: If `req_i` is held high, a new code starts at the edge that follows the waiting cycle. The output then repeats with a period of CODE_W+1 cycles (1,1,0,1,0 for the default).
- R8: A reset asserted during sending stops the code at once. `bit_o` is 0 in the next cycle and stays 0 until a later request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Identification request from the host, sampled at rising edges |
| bit_o | output | 1 | Serial code bit, least significant first; 0 while waiting |

## Verification
The first pattern is a single-cycle request pulse. It shows the start latency and the bit order, and it shows that the wire falls back to 0 after the last bit. A second pulse is followed by request activity during sending, which separates a design that ignores a mid-code request from one that restarts or skips bits. A request held high for many cycles shows whether the mandatory waiting cycle and the repeat period are right. A reset during sending, and a request held during reset, show that reset takes priority over both transmission and request.

// File: rtl/skr_pkg.sv
package skr_pkg;
  localparam int unsigned    SKR_DEF_W    = 4;
  localparam logic [3:0]     SKR_DEF_CODE = 4'b1011;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_SEND = 2'd1,
    PH_LAST = 2'd2
  } skr_phase_e;
endpackage

// File: rtl/skr_phase_dec.sv
module skr_phase_dec
  import skr_pkg::*;
#(
  parameter int unsigned CODE_W = SKR_DEF_W,
  localparam int unsigned IW = $clog2(CODE_W + 1)
) (
  input  logic [IW-1:0] slot_i,
  output skr_phase_e    phase_o
);
  always_comb begin
    if (slot_i == '0)
      phase_o = PH_WAIT;
    else if (slot_i == IW'(CODE_W))
      phase_o = PH_LAST;
    else
      phase_o = PH_SEND;
  end
endmodule

// File: rtl/skr_step.sv
module skr_step
  import skr_pkg::*;
#(
  parameter int unsigned CODE_W = SKR_DEF_W,
  localparam int unsigned IW = $clog2(CODE_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  skr_phase_e    phase_i,
  output logic [IW-1:0] slot_o
);
  logic [IW-1:0] slot_d;

  // slot 0 = waiting, slot k = sending code bit k-1
  always_comb begin
    unique case (phase_i)
      PH_WAIT: slot_d = req_i ? IW'(1) : '0;
      PH_SEND: slot_d = slot_o + IW'(1);
      default: slot_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) slot_o <= '0;
    else     slot_o <= slot_d;
  end
endmodule

// File: rtl/skr_bitmux.sv
module skr_bitmux
  import skr_pkg::*;
#(
  parameter int unsigned       CODE_W = SKR_DEF_W,
  parameter logic [CODE_W-1:0] CODE   = SKR_DEF_CODE,
  localparam int unsigned IW = $clog2(CODE_W + 1)
) (
  input  logic [IW-1:0] slot_i,
  output logic          bit_o
);
  logic [CODE_W-1:0] hit;

  for (genvar g = 0; g < CODE_W; g++) begin : g_tap
    if (CODE[g]) begin : g_one
      assign hit[g] = (slot_i == IW'(g + 1));
    end else begin : g_zero
      assign hit[g] = 1'b0;
    end
  end

  assign bit_o = |hit;
endmodule

// File: rtl/serial_key_responder.sv
module serial_key_responder
  import skr_pkg::*;
#(
  parameter int unsigned       CODE_W = SKR_DEF_W,
  parameter logic [CODE_W-1:0] CODE   = SKR_DEF_CODE
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic bit_o
);
  localparam int unsigned IW = $clog2(CODE_W + 1);

  logic [IW-1:0] slot;
  skr_phase_e    phase;

  skr_phase_dec #(.CODE_W(CODE_W)) u_dec (
    .slot_i (slot),
    .phase_o(phase)
  );

  skr_step #(.CODE_W(CODE_W)) u_step (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .phase_i(phase),
    .slot_o (slot)
  );

  skr_bitmux #(.CODE_W(CODE_W), .CODE(CODE)) u_mux (
    .slot_i(slot),
    .bit_o (bit_o)
  );
endmodule

// File: rtl/skr_checker.sv
module skr_checker #(
  parameter int unsigned       CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE   = 4'b1011,
  localparam int unsigned IW = $clog2(CODE_W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_i,
  input logic          bit_o,
  input logic [IW-1:0] slot
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slot == '0 && !bit_o));

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    (slot == '0) |-> !bit_o);

  assert_start_lsb_R3: assert property (@(posedge clk) disable iff (rst)
    (slot == '0 && req_i) |=> (slot == IW'(1) && bit_o == CODE[0]));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (slot != '0 && slot != IW'(CODE_W)) |=> (slot == $past(slot) + IW'(1)));

  assert_return_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (slot == IW'(CODE_W)) |=> (slot == '0));

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (slot != '0) |=> (slot != IW'(1)));
endmodule

bind serial_key_responder skr_checker #(.CODE_W(CODE_W), .CODE(CODE)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .req_i(req_i),
  .bit_o(bit_o),
  .slot (slot)
);

// File: tb/serial_key_responder_bench.sv
module serial_key_responder_bench;
  localparam int unsigned    W    = 4;
  localparam logic [W-1:0]   CODE = 4'b1011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic bit_o;

  int checks = 0;
  int errors = 0;
  int ref_idx = 0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  serial_key_responder #(.CODE_W(W), .CODE(CODE)) u_serial_key_responder (
    .clk  (clk),
    .rst  (rst),
    .req_i(req),
    .bit_o(bit_o)
  );

  // behavioural reference: index 0 waits, 1..W send code bit index-1
  always @(posedge clk) begin
    if (rst)               ref_idx <= 0;
    else if (ref_idx == 0) ref_idx <= req ? 1 : 0;
    else if (ref_idx == W) ref_idx <= 0;
    else                   ref_idx <= ref_idx + 1;
    cmp_en <= 1'b1;
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic e;
      e = (ref_idx == 0) ? 1'b0 : CODE[ref_idx-1];
      checks++;
      if (bit_o !== e) begin
        errors++;
        $display("FAIL %s model: bit_o=%b expected=%b",
                 (ref_idx == 0) ? "R2" : ((ref_idx == 1) ? "R3" : "R4"), bit_o, e);
      end
    end
  end

  // at each negedge: check the output, then drive this cycle's inputs
  task automatic run_seq(input string tag, input int n, input logic [15:0] rq,
                         input logic [15:0] rs, input logic [15:0] ex);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (bit_o !== ex[i]) begin
        errors++;
        $display("FAIL %s step %0d: bit_o=%b expected=%b", tag, i, bit_o, ex[i]);
      end
      req = rq[i];
      rst = rs[i];
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req = 1'b0;
      rst = 1'b0;
    end
  endtask

  initial begin
    // R1: reset with a request held high still keeps the wire low
    req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bit_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: bit_o=%b expected=0", bit_o);
    end
    req = 1'b0;
    rst = 1'b0;
    // R2: idle with no request
    run_seq("R2", 5, 16'h0000, 16'h0000, 16'h0000);
    // R3 R4 R5: single pulse gives 1,1,0,1 then low
    run_seq("R4", 7, 16'h0001, 16'h0000, 16'h0016);
    drain();
    // R6: request high during sending is ignored
    run_seq("R6", 7, 16'h000D, 16'h0000, 16'h0016);
    drain();
    // R7 R5: held request repeats with one waiting cycle
    run_seq("R7", 11, 16'h07FF, 16'h0000, 16'h02D6);
    drain();
    // R8: reset while sending aborts
    run_seq("R8", 6, 16'h0001, 16'h0004, 16'h0006);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule